// File: doc/BRIEF.md
# Bit-Manipulation Functional Unit

This unit performs irregular bit-level operations on 32-bit operands for a vector datapath. A 3-bit opcode picks one of six operations: population count, bit reversal, two-source bit interleave, one-source deinterleave into two results, highest-set-bit index, and an approximate base-2 logarithm. An operation is presented with `valid_i`, two sources and the opcode. Its results leave on two result buses under `valid_o`.

The issue side may present a new operation every clock. Every opcode, including deinterleave, delivers its results exactly two clock edges after it is accepted. A scheduler therefore sees a single fixed latency, and results never collide at the output. Deinterleave is computed in the issue cycle and carried through the pipe. All other operations are evaluated in the second cycle from registered operands. The second result bus carries data only for deinterleave.

Top module: `bmu_top`

## Requirements
- R1: While rst_ni is low and after its release, before any operation is accepted, valid_o is 0 and both results are 0.
- R2: An operation accepted with valid_i=1 at a rising edge appears with valid_o=1 at the second following rising edge. Back-to-back operations leave in issue order, one per cycle.
- R3: Opcode 0 (population count) returns in res1_o the number of one bits in src1_i.
- R4: Opcode 1 (reverse) returns res1_o[i] = src1_i[31-i].
- R5: Opcode 2 (interleave) returns res1_o[2i] = src1_i[i] and res1_o[2i+1] = src2_i[i] for i in 0..15. Bits 31..16 of both sources are ignored.
- R6: Opcode 3 (deinterleave) returns res1_o[i] = src1_i[2i] and res2_o[i] = src1_i[2i+1] for i in 0..15. Bits 31..16 of both results are 0.
- R7: Opcode 4 (highest set bit) returns in res1_o the index (0..31) of the most significant one bit of src1_i. It returns 32'hFFFF_FFFF when src1_i is 0.
- R8: Opcode 5 (approximate log2) returns res1_o = {23'b0, n[4:0], f[3:0]}. Here n is the highest-set-bit index and f holds src1_i bits n-1 down to n-4, with positions below bit 0 read as 0. It returns 32'hFFFF_FFFF when src1_i is 0.
- R9: Every opcode except 3 gives res2_o = 0. Opcodes 6 and 7 give res1_o = res2_o = 0, still with valid_o = 1.
- R10: In a cycle where valid_o is 0, res1_o and res2_o are 0, whatever the sources and opcode were while valid_i was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Opcode (0..5 used) |
| src1_i | input | 32 | First source |
| src2_i | input | 32 | Second source |
| valid_o | output | 1 | Results present this cycle |
| res1_o | output | 32 | First result |
| res2_o | output | 32 | Second result (deinterleave only) |

## Verification
The bench builds the unit with its defaults: a 32-bit operand and a 4-bit log fraction. At those values the full-range corners can be reached directly. These include a population count of 32, reversal across the whole word, a highest-bit index of 31 and the largest log code 0x1FF. Log inputs with fewer than four bits below the leading one exercise the zero fill of the fraction. A back-to-back burst that mixes deinterleave with one-slot operations shows that the uniform latency keeps every result in order and free of collisions.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [2:0] {
    OP_POPCNT = 3'd0,
    OP_BREV   = 3'd1,
    OP_ILV    = 3'd2,
    OP_DILV   = 3'd3,
    OP_LMBD   = 3'd4,
    OP_LOG    = 3'd5
  } bmu_op_e;
endpackage

// File: rtl/bmu_issue.sv
module bmu_issue #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  output logic              s1_valid_o,
  output logic [2:0]        s1_op_o,
  output logic [DATA_W-1:0] s1_src1_o,
  output logic [DATA_W-1:0] s1_src2_o,
  output logic [DATA_W-1:0] s1_even_o,
  output logic [DATA_W-1:0] s1_odd_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] even_d, odd_d;

  // deinterleave has no delay slot: computed at issue
  for (genvar i = 0; i < HALF_W; i++) begin : g_split
    assign even_d[i] = src1_i[2*i];
    assign odd_d[i]  = src1_i[2*i+1];
  end
  assign even_d[DATA_W-1:HALF_W] = '0;
  assign odd_d[DATA_W-1:HALF_W]  = '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_o <= 1'b0;
      s1_op_o    <= '0;
      s1_src1_o  <= '0;
      s1_src2_o  <= '0;
      s1_even_o  <= '0;
      s1_odd_o   <= '0;
    end else begin
      s1_valid_o <= valid_i;
      if (valid_i) begin
        s1_op_o   <= op_i;
        s1_src1_o <= src1_i;
        s1_src2_o <= src2_i;
        s1_even_o <= even_d;
        s1_odd_o  <= odd_d;
      end
    end
  end
endmodule

// File: rtl/bmu_count.sv
module bmu_count #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_i,
  output logic [IDX_W:0]    ones_o,
  output logic [IDX_W-1:0]  msb_idx_o,
  output logic              zero_o
);
  always_comb begin
    ones_o    = '0;
    msb_idx_o = '0;
    for (int i = 0; i < DATA_W; i++) begin
      ones_o = ones_o + (IDX_W+1)'(src_i[i]);
      if (src_i[i]) msb_idx_o = IDX_W'(i);
    end
  end
  assign zero_o = (src_i == '0);
endmodule

// File: rtl/bmu_perm.sv
module bmu_perm #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  output logic [DATA_W-1:0] rev_o,
  output logic [DATA_W-1:0] ilv_o
);
  localparam int HALF_W = DATA_W / 2;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev_o[i] = src1_i[DATA_W-1-i];
  end
  for (genvar i = 0; i < HALF_W; i++) begin : g_ilv
    assign ilv_o[2*i]   = src1_i[i];
    assign ilv_o[2*i+1] = src2_i[i];
  end
endmodule

// File: rtl/bmu_top.sv
module bmu_top #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res1_o,
  output logic [DATA_W-1:0] res2_o
);
  import bmu_pkg::*;

  localparam int IDX_W = $clog2(DATA_W);
  localparam int LOG_W = IDX_W + FRAC_W;

  logic              s1_valid;
  logic [2:0]        s1_op;
  logic [DATA_W-1:0] s1_src1, s1_src2, s1_even, s1_odd;
  logic [IDX_W:0]    ones;
  logic [IDX_W-1:0]  msb_idx;
  logic              is_zero;
  logic [DATA_W-1:0] rev, ilv, norm;
  logic [FRAC_W-1:0] frac;
  logic [DATA_W-1:0] r1_d, r2_d;

  bmu_issue #(.DATA_W(DATA_W)) u_issue (
    .clk_i, .rst_ni, .valid_i, .op_i, .src1_i, .src2_i,
    .s1_valid_o(s1_valid), .s1_op_o(s1_op),
    .s1_src1_o(s1_src1), .s1_src2_o(s1_src2),
    .s1_even_o(s1_even), .s1_odd_o(s1_odd)
  );

  bmu_count #(.DATA_W(DATA_W)) u_count (
    .src_i(s1_src1), .ones_o(ones), .msb_idx_o(msb_idx), .zero_o(is_zero)
  );

  bmu_perm #(.DATA_W(DATA_W)) u_perm (
    .src1_i(s1_src1), .src2_i(s1_src2), .rev_o(rev), .ilv_o(ilv)
  );

  // normalise so the leading one sits at the top; fraction is just below it
  assign norm = s1_src1 << (IDX_W'(DATA_W-1) - msb_idx);
  assign frac = norm[DATA_W-2 -: FRAC_W];

  always_comb begin
    r1_d = '0;
    r2_d = '0;
    unique case (s1_op)
      3'(OP_POPCNT): r1_d = DATA_W'(ones);
      3'(OP_BREV):   r1_d = rev;
      3'(OP_ILV):    r1_d = ilv;
      3'(OP_DILV): begin
        r1_d = s1_even;
        r2_d = s1_odd;
      end
      3'(OP_LMBD):   r1_d = is_zero ? '1 : DATA_W'(msb_idx);
      3'(OP_LOG):    r1_d = is_zero ? '1 : DATA_W'({msb_idx, frac});
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res1_o  <= '0;
      res2_o  <= '0;
    end else begin
      valid_o <= s1_valid;
      res1_o  <= s1_valid ? r1_d : '0;
      res2_o  <= s1_valid ? r2_d : '0;
    end
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i, 2));

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (res1_o == '0 && res2_o == '0));

  p_single_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(s1_op) != 3'(OP_DILV)) |-> res2_o == '0);

  p_pop_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(s1_op) == 3'(OP_POPCNT)) |-> res1_o <= DATA_W);

  p_lmbd_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(s1_op) == 3'(OP_LMBD)) |-> (res1_o < DATA_W || res1_o == '1));

  p_log_width_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(s1_op) == 3'(OP_LOG)) |-> (res1_o >> LOG_W == '0 || res1_o == '1));
endmodule

// File: tb/bmu_top_tb_top.sv
module bmu_top_tb_top;
  localparam int NV = 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] src1_i = '0, src2_i = '0;
  logic        valid_o;
  logic [31:0] res1_o, res2_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bmu_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .src1_i(src1_i), .src2_i(src2_i),
    .valid_o(valid_o), .res1_o(res1_o), .res2_o(res2_o)
  );

  // {op, src1, src2, exp1, exp2}
  localparam logic [130:0] VEC [NV] = '{
    {3'd0, 32'hFFFF_FFFF, 32'h0,         32'h0000_0020, 32'h0},
    {3'd0, 32'h8000_0001, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0},
    {3'd0, 32'h0,         32'h0,         32'h0,         32'h0},
    {3'd1, 32'h0000_0001, 32'h0,         32'h8000_0000, 32'h0},
    {3'd1, 32'h1234_5678, 32'h0,         32'h1E6A_2C48, 32'h0},
    {3'd2, 32'h0000_FFFF, 32'h0,         32'h5555_5555, 32'h0},
    {3'd2, 32'h0,         32'h0000_FFFF, 32'hAAAA_AAAA, 32'h0},
    {3'd2, 32'hFFFF_0000, 32'hFFFF_0001, 32'h0000_0002, 32'h0},
    {3'd3, 32'hAAAA_AAAA, 32'h0,         32'h0,         32'h0000_FFFF},
    {3'd3, 32'h0000_0006, 32'h0,         32'h0000_0002, 32'h0000_0001},
    {3'd3, 32'h5555_5555, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0},
    {3'd4, 32'h0000_0001, 32'h0,         32'h0,         32'h0},
    {3'd4, 32'h8000_0000, 32'h0,         32'h0000_001F, 32'h0},
    {3'd4, 32'h0,         32'h0,         32'hFFFF_FFFF, 32'h0},
    {3'd5, 32'h0000_0001, 32'h0,         32'h0,         32'h0},
    {3'd5, 32'h0000_0003, 32'h0,         32'h0000_0018, 32'h0},
    {3'd5, 32'hFFFF_FFFF, 32'h0,         32'h0000_01FF, 32'h0},
    {3'd5, 32'h0000_0140, 32'h0,         32'h0000_0084, 32'h0},
    {3'd5, 32'h0000_0100, 32'h0,         32'h0000_0080, 32'h0},
    {3'd5, 32'h0,         32'h0,         32'hFFFF_FFFF, 32'h0},
    {3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,         32'h0},
    {3'd7, 32'h1234_5678, 32'h0000_FFFF, 32'h0,         32'h0}
  };

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    valid_i = 1'b1; op_i = op; src1_i = a; src2_i = b;
  endtask

  task automatic run_vec(input logic [130:0] v);
    string r;
    r = req_of(v[130:128]);
    issue(v[130:128], v[127:96], v[95:64]);
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    check("R2", "valid_o", 32'(valid_o), 32'd1);
    check(r, "res1_o", res1_o, v[63:32]);
    check(v[130:128] == 3'd3 ? "R6" : "R9", "res2_o", res2_o, v[31:0]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "valid_o in reset", 32'(valid_o), 32'd0);
    check("R1", "res1_o in reset", res1_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", "valid_o after reset", 32'(valid_o), 32'd0);
    check("R1", "res2_o after reset", res2_o, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R10: sources move while idle, outputs stay quiet
    op_i = 3'd3; src1_i = 32'hFFFF_FFFF; src2_i = 32'hFFFF_FFFF;
    @(negedge clk);
    src1_i = 32'h1357_9BDF;
    @(negedge clk);
    @(negedge clk);
    check("R10", "valid_o idle", 32'(valid_o), 32'd0);
    check("R10", "res1_o idle", res1_o, 32'd0);
    check("R10", "res2_o idle", res2_o, 32'd0);

    // R2: back-to-back burst, deinterleave between one-slot ops
    issue(3'd0, 32'h0000_00FF, 32'h0);
    @(negedge clk);
    issue(3'd3, 32'h0000_000F, 32'h0);
    @(negedge clk);
    check("R2", "burst first res1_o", res1_o, 32'h0000_0008);
    issue(3'd1, 32'h0000_0003, 32'h0);
    @(negedge clk);
    valid_i = 1'b0;
    check("R2", "burst second res1_o", res1_o, 32'h0000_0003);
    check("R2", "burst second res2_o", res2_o, 32'h0000_0003);
    @(negedge clk);
    check("R2", "burst third res1_o", res1_o, 32'hC000_0000);
    check("R2", "burst third valid_o", 32'(valid_o), 32'd1);
    @(negedge clk);
    check("R2", "burst end valid_o", 32'(valid_o), 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule